// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether an I/O port access of one, two or four bytes may go ahead. It takes the port number, the access size and the current task-segment register (base, limit, present flag and type field), and returns a one-cycle verdict of either allow or general-protection fault. The fault always carries error code 0.

The descriptor is checked first, and a bad descriptor faults without any memory traffic. If it passes, the block reads a 16-bit bitmap pointer stored inside the task segment. It adds the port's byte index to that pointer and checks that two bytes at that position lie within the segment limit. It then reads those two bytes. The access is allowed only when every permission bit covered by the access is clear. Because the bitmap word is fetched as two bytes, an access whose bits straddle a byte boundary is handled correctly.

Both reads go through a supervisor-privilege memory port with a request/response handshake, and only one read is in flight at a time. Requests are taken one at a time through a valid/ready pair.

Top module: `io_perm_checker`

## Requirements
- R1: A request faults with no memory read when the segment is not present, its 4-bit type is not 9, or its limit is below 103.
- R2: Size is encoded 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes. Code 11 faults with no memory read.
- R3: The first read goes to segment base + 0x66, and every memory request is marked supervisor (mem_req_kernel = 1).
- R4: The read data is little-endian: bits 7:0 hold the byte at the request address. The bitmap byte offset is the fetched pointer plus port >> 3, and the second read goes to segment base + that offset.
- R5: If the offset + 1 exceeds the limit, the request faults after exactly one read. The compare is 32-bit unsigned and cannot wrap.
- R6: The second word is shifted right by port[2:0]. The access is allowed only if the low 1, 2 or 4 bits (by size) are all zero, including when they span two bitmap bytes.
- R7: An error response on either read gives a fault, and no further read is issued.
- R8: req_ready is high only when idle. Each accepted request yields exactly one single-cycle done pulse with exactly one of allow or fault. fault_code is 0.
- R9: At most one memory read is outstanding. A request is held with a stable address until accepted.
- R10: After reset, req_ready = 1, done = 0 and mem_req_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Check request valid |
| req_ready | output | 1 | Block idle and accepting |
| req_port | input | 16 | I/O port number |
| req_size | input | 2 | Access size code |
| tss_base | input | 32 | Task segment base address |
| tss_limit | input | 32 | Task segment limit |
| tss_present | input | 1 | Segment present flag |
| tss_type | input | 4 | Segment type field |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of 16-bit read |
| mem_req_kernel | output | 1 | Supervisor access flag |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 16 | Read data, little-endian |
| mem_rsp_err | input | 1 | Read response error |
| done | output | 1 | Verdict pulse |
| allow | output | 1 | Access permitted (with done) |
| fault | output | 1 | General-protection fault (with done) |
| fault_code | output | 16 | Fault error code |

## Verification
The assertions check on every cycle that memory requests are held stable until accepted, that only one read is outstanding, that done is a single pulse, and that a bad descriptor or an error response leads straight to a fault. The bench scenarios are needed to show the verdict itself: the pointer and bitmap addresses, little-endian assembly, the limit boundary on both sides, and masks that straddle two bitmap bytes. The bench checks these against a reference model of the bitmap memory.

// File: rtl/io_perm_checker.sv
module io_perm_checker #(
  parameter int AW         = 32,
  parameter int PW         = 16,
  parameter int MIN_LIMIT  = 103,
  parameter int PTR_OFS    = 'h66,
  parameter logic [3:0] TSS_TYPE = 4'd9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [PW-1:0] req_port,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] tss_base,
  input  logic [AW-1:0] tss_limit,
  input  logic          tss_present,
  input  logic [3:0]    tss_type,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_kernel,
  input  logic          mem_rsp_valid,
  input  logic [15:0]   mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          done,
  output logic          allow,
  output logic          fault,
  output logic [15:0]   fault_code
);
  localparam int BW = PW - 3;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK_DESC, S_READ_BASE, S_CHECK_LIMIT, S_READ_MAP, S_DONE
  } state_t;

  state_t        state;
  logic          issued, ok_q;
  logic [PW-1:0] port_q;
  logic [1:0]    size_q;
  logic [AW-1:0] base_q, limit_q;
  logic          pres_q;
  logic [3:0]    type_q;
  logic [15:0]   ptr_q;

  logic          desc_bad;
  logic [AW-1:0] map_off, map_end;
  logic [15:0]   window;
  logic [3:0]    mask;

  assign desc_bad = !pres_q || (type_q != TSS_TYPE) ||
                    (limit_q < AW'(MIN_LIMIT)) || (size_q == 2'b11);
  assign map_off  = AW'(ptr_q) + AW'(port_q[PW-1:3]);
  assign map_end  = map_off + AW'(1);
  assign window   = mem_rsp_data >> port_q[2:0];
  assign mask     = (size_q == 2'b00) ? 4'b0001 :
                    (size_q == 2'b01) ? 4'b0011 : 4'b1111;

  assign req_ready      = (state == S_IDLE);
  assign mem_req_valid  = ((state == S_READ_BASE) || (state == S_READ_MAP)) && !issued;
  assign mem_req_addr   = (state == S_READ_BASE) ? base_q + AW'(PTR_OFS) : base_q + map_off;
  assign mem_req_kernel = 1'b1;
  assign done           = (state == S_DONE);
  assign allow          = done && ok_q;
  assign fault          = done && !ok_q;
  assign fault_code     = 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      issued  <= 1'b0;
      ok_q    <= 1'b0;
      port_q  <= '0;
      size_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
      pres_q  <= 1'b0;
      type_q  <= '0;
      ptr_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          port_q  <= req_port;
          size_q  <= req_size;
          base_q  <= tss_base;
          limit_q <= tss_limit;
          pres_q  <= tss_present;
          type_q  <= tss_type;
          state   <= S_CHECK_DESC;
        end
        S_CHECK_DESC: begin
          if (desc_bad) begin
            ok_q  <= 1'b0;
            state <= S_DONE;
          end else begin
            state <= S_READ_BASE;
          end
        end
        S_READ_BASE: begin
          if (!issued) begin
            if (mem_req_ready) issued <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued <= 1'b0;
            if (mem_rsp_err) begin
              ok_q  <= 1'b0;
              state <= S_DONE;
            end else begin
              ptr_q <= mem_rsp_data;
              state <= S_CHECK_LIMIT;
            end
          end
        end
        S_CHECK_LIMIT: begin
          if (map_end > limit_q) begin
            ok_q  <= 1'b0;
            state <= S_DONE;
          end else begin
            state <= S_READ_MAP;
          end
        end
        S_READ_MAP: begin
          if (!issued) begin
            if (mem_req_ready) issued <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued <= 1'b0;
            ok_q   <= !mem_rsp_err && ((window[3:0] & mask) == 4'b0000);
            state  <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !done);

  p_desc_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK_DESC) && desc_bad |=> fault && !mem_req_valid);

  p_err_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issued && mem_rsp_valid && mem_rsp_err |=> fault);

  p_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_kernel);
endmodule

// File: tb/io_perm_checker_bench.sv
`timescale 1ns/1ps
module io_perm_checker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [15:0] req_port = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] tss_base = '0, tss_limit = '0;
  logic tss_present = 1'b0;
  logic [3:0] tss_type = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_kernel;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic done, allow, fault;
  logic [15:0] fault_code;

  io_perm_checker u_io_perm_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_size(req_size), .tss_base(tss_base),
    .tss_limit(tss_limit), .tss_present(tss_present), .tss_type(tss_type),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_kernel(mem_req_kernel),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .done(done), .allow(allow), .fault(fault),
    .fault_code(fault_code));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] bmem [0:1023];

  int          n_reads, err_at, busy, lat;
  logic [31:0] rd_addr [0:3];
  logic        rd_kern [0:3];
  logic [31:0] pend_addr;
  logic        stall_tog;

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      busy = 0; stall_tog = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (mem_req_ready) begin
        if (n_reads < 4) begin
          rd_addr[n_reads] = pend_addr;
          rd_kern[n_reads] = mem_req_kernel;
        end
        n_reads++;
        busy = 1; lat = 2;
        mem_req_ready = 1'b0;
      end else if (busy != 0) begin
        lat--;
        if (lat == 0) begin
          busy = 0;
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = {bmem[(pend_addr + 32'd1) & 32'h3FF], bmem[pend_addr & 32'h3FF]};
          mem_rsp_err   = (err_at == n_reads);
        end
      end else if (mem_req_valid) begin
        stall_tog = ~stall_tog;
        if (stall_tog) begin
          mem_req_ready = 1'b1;
          pend_addr = mem_req_addr;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  function automatic void ref_eval(input logic [15:0] p, input logic [1:0] sz,
      input logic [31:0] base, input logic [31:0] lim, input logic pres, input logic [3:0] ty,
      input int e_at, output bit ok, output int reads, output logic [31:0] a2);
    logic [15:0] ptr, w;
    logic [31:0] off;
    int width;
    ok = 1'b0; reads = 0; a2 = '0;
    if (!pres || ty != 4'd9 || lim < 32'd103 || sz == 2'b11) return;
    reads = 1;
    if (e_at == 1) return;
    ptr = {bmem[(base + 32'h67) & 32'h3FF], bmem[(base + 32'h66) & 32'h3FF]};
    off = {16'h0, ptr} + {19'h0, p[15:3]};
    a2  = base + off;
    if (off + 32'd1 > lim) return;
    reads = 2;
    if (e_at == 2) return;
    w = {bmem[(a2 + 32'd1) & 32'h3FF], bmem[a2 & 32'h3FF]} >> p[2:0];
    width = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    ok = ((w & 16'((1 << width) - 1)) == 16'h0);
  endfunction

  task automatic run(input logic [15:0] p, input logic [1:0] sz, input logic [31:0] base,
      input logic [31:0] lim, input logic pres, input logic [3:0] ty, input int e_at, input string tag);
    bit ok_exp; int reads_exp; logic [31:0] a2; int waitc; bit seen;
    ref_eval(p, sz, base, lim, pres, ty, e_at, ok_exp, reads_exp, a2);
    @(negedge clk);
    n_reads = 0; err_at = e_at;
    req_port = p; req_size = sz; tss_base = base; tss_limit = lim;
    tss_present = pres; tss_type = ty; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (waitc = 0; waitc < 60 && !seen; waitc++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    check(seen, {tag, " R8 done"}, seen, 1);
    if (seen) begin
      check(allow == ok_exp && fault == !ok_exp, {tag, " verdict R6"}, allow, ok_exp);
      check(!fault || fault_code == 16'h0, {tag, " R8 code"}, fault_code, 0);
      check(n_reads == reads_exp, {tag, " reads R1 R5"}, n_reads, reads_exp);
      if (reads_exp >= 1 && n_reads >= 1) begin
        check(rd_addr[0] == base + 32'h66, {tag, " R3 ptr addr"}, rd_addr[0], base + 32'h66);
        check(rd_kern[0] == 1'b1, {tag, " R3 kernel"}, rd_kern[0], 1);
      end
      if (reads_exp == 2 && n_reads == 2)
        check(rd_addr[1] == a2, {tag, " R4 map addr"}, rd_addr[1], a2);
      @(negedge clk);
      check(!done && req_ready, {tag, " R8 pulse"}, done, 0);
    end
  endtask

  localparam int NV = 14;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {16'h0000, 2'b00}, {16'h0000, 2'b10}, {16'h0006, 2'b01}, {16'h0006, 2'b10},
    {16'h0007, 2'b00}, {16'h0008, 2'b00}, {16'h000D, 2'b10}, {16'h0013, 2'b01},
    {16'h0022, 2'b10}, {16'h0041, 2'b00}, {16'h0075, 2'b01}, {16'h0077, 2'b00},
    {16'h0078, 2'b00}, {16'h0003, 2'b11}
  };

  initial begin
    n_reads = 0; err_at = 0; pend_addr = '0;
    for (int i = 0; i < 1024; i++) bmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    bmem[32'h166] = 8'h70; bmem[32'h167] = 8'h00;
    bmem[32'h170] = 8'h00; bmem[32'h171] = 8'h01;
    bmem[32'h172] = 8'h00; bmem[32'h173] = 8'h00;
    bmem[32'h266] = 8'h68; bmem[32'h267] = 8'h00;

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10 ready", req_ready, 1);
    check(done == 1'b0, "R10 done", done, 0);
    check(mem_req_valid == 1'b0, "R10 memreq", mem_req_valid, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run(VEC[v][17:2], VEC[v][1:0], 32'h100, 32'h7F, 1'b1, 4'd9, 0, "R6 table");

    run(16'h0006, 2'b10, 32'h100, 32'h7F, 1'b1, 4'd9, 0, "R6 span");
    run(16'h0001, 2'b00, 32'h100, 32'h7F, 1'b0, 4'd9, 0, "R1 absent");
    run(16'h0001, 2'b00, 32'h100, 32'h7F, 1'b1, 4'hB, 0, "R1 type");
    run(16'h0001, 2'b00, 32'h100, 32'd102, 1'b1, 4'd9, 0, "R1 lim102");
    run(16'h0001, 2'b00, 32'h100, 32'd103, 1'b1, 4'd9, 0, "R5 lim103");
    run(16'h0001, 2'b11, 32'h100, 32'h7F, 1'b1, 4'd9, 0, "R2 size11");
    run(16'h0020, 2'b01, 32'h100, 32'h7F, 1'b1, 4'd9, 0, "R2 word");
    run(16'hFFFF, 2'b00, 32'h200, 32'h2067, 1'b1, 4'd9, 0, "R5 top-fault");
    run(16'hFFFF, 2'b00, 32'h200, 32'h2068, 1'b1, 4'd9, 0, "R5 top-edge");
    run(16'h0000, 2'b00, 32'h100, 32'h7F, 1'b1, 4'd9, 1, "R7 err1");
    run(16'h0000, 2'b00, 32'h100, 32'h7F, 1'b1, 4'd9, 2, "R7 err2");
    run(16'h0010, 2'b00, 32'h100, 32'h7F, 1'b1, 4'd9, 0, "R4 R9 after err");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule